// File: doc/BRIEF.md
# ULPI Transceiver Register Array

This block is the register file on the transceiver side of a ULPI immediate-access port. An access decoder ahead of it presents one decoded access per cycle: a valid strobe, a 6-bit address, a write flag and an 8-bit write value. Writes update the array. Reads return their byte one clock later on a registered data output, marked by a one-cycle valid pulse.

Four control registers each occupy three consecutive addresses. The first address loads the whole byte, the second sets the bits that are 1 in the written value, and the third clears those bits. Any of the three addresses reads back the current value. These four registers hold the function controls, the on-the-go controls, the rising-edge interrupt enables and a scratch byte. The function and on-the-go controls also leave the block as ports, where they drive the analog side.

Two read-only registers show live inputs: the interrupt sources and the two line-state bits. An interrupt latch register captures rising edges of the enabled sources and clears itself when it is read. A 16-byte vendor window at the top of the address space gives plain read/write storage.

Top module: `ulpi_reg_array`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0, `func_ctrl` and `otg_ctrl` are 00h, and reads of 04h, 0Ah, 0Dh, 16h, 14h return 00h.
- R2: A write to the base address of a control register (04h function, 0Ah on-the-go, 0Dh interrupt enable, 16h scratch) loads the written byte, and the value reads back identically at base, base+1 and base+2.
- R3: A write to base+1 ORs the written byte into the register. A write to base+2 clears the bits that are 1 in the written byte. Other bits are kept.
- R4: Address 13h reads the current level of each source: bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end, bit 4 ID ground, bits 7:5 zero. These map to `irq_src[0]` through `irq_src[4]`.
- R5: Address 15h reads `line_state[0]` in bit 0 and `line_state[1]` in bit 1, with bits 7:2 zero.
- R6: The latch register at 14h uses the same bit order as 13h. A latch bit sets on a 0-to-1 change of its source only if the matching bit of the enable register (0Dh) is 1. Falling edges and disabled sources set nothing.
- R7: A read of 14h returns the latched bits and clears them. If a rise arrives in the same cycle as that read, its bit stays set and appears on the next read.
- R8: Addresses 30h to 3Fh form 16 independent read/write bytes.
- R9: Writes to 13h, 14h, 15h and to unimplemented addresses change nothing. Reads of unimplemented addresses (for example 01h, 19h, 20h, 2Fh) return 00h.
- R10: Read data and `rd_valid` appear on the clock edge after the read access. `rd_valid` is 0 after any cycle without a read. `func_ctrl` and `otg_ctrl` show the register value from the edge after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Register address |
| acc_wdata | input | 8 | Write value |
| irq_src | input | 5 | Live interrupt source levels |
| line_state | input | 2 | Live line-state bits |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| func_ctrl | output | 8 | Function control register value |
| otg_ctrl | output | 8 | On-the-go control register value |

## Verification
The hardest case to reach is a source rise that lands on the same clock edge as a read of the latch register. The read must return the old contents, and the new bit must survive the clear. The bench first leaves the source low for at least one edge. It then changes the source and presents the read of 14h on the same falling edge, so both are seen by one rising edge. A second read confirms that the bit was kept. Ignored writes to the read-only addresses are shown at the ports: the latch, status and debug registers are read back right after each such write.

// File: rtl/ulpi_reg_pkg.sv
`timescale 1ns/1ps
package ulpi_reg_pkg;
  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int NSRC = 5;

  // Base addresses of the three-alias control registers
  localparam int NALIAS = 4;
  localparam logic [AW-1:0] A_FUNC    = 6'h04;
  localparam logic [AW-1:0] A_OTG     = 6'h0A;
  localparam logic [AW-1:0] A_IEN     = 6'h0D;
  localparam logic [AW-1:0] A_SCRATCH = 6'h16;

  // Read-only registers
  localparam logic [AW-1:0] A_STATUS  = 6'h13;
  localparam logic [AW-1:0] A_LATCH   = 6'h14;
  localparam logic [AW-1:0] A_DEBUG   = 6'h15;

  // Vendor window
  localparam logic [AW-1:0] A_VEND    = 6'h30;
  localparam int VEND_DEPTH = 16;

  // Index of each alias register in the generated array
  typedef enum int {IX_FUNC = 0, IX_OTG = 1, IX_IEN = 2, IX_SCRATCH = 3} alias_ix_e;

  function automatic logic [AW-1:0] alias_base(input int ix);
    case (ix)
      IX_FUNC:  alias_base = A_FUNC;
      IX_OTG:   alias_base = A_OTG;
      IX_IEN:   alias_base = A_IEN;
      default:  alias_base = A_SCRATCH;
    endcase
  endfunction
endpackage

// File: rtl/ulpi_alias_reg.sv
`timescale 1ns/1ps
module ulpi_alias_reg #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] q
);
  localparam logic [AW-1:0] A_LOAD = BASE;
  localparam logic [AW-1:0] A_SET  = BASE + AW'(1);
  localparam logic [AW-1:0] A_CLR  = BASE + AW'(2);

  assign hit = (addr == A_LOAD) || (addr == A_SET) || (addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      if (addr == A_LOAD)     q <= wdata;
      else if (addr == A_SET) q <= q | wdata;
      else if (addr == A_CLR) q <= q & ~wdata;
    end
  end
endmodule

// File: rtl/ulpi_irq_latch.sv
`timescale 1ns/1ps
module ulpi_irq_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] rise_en,
  input  logic         rd_clr,
  output logic [N-1:0] lat
);
  logic [N-1:0] src_d;
  logic [N-1:0] rise;

  assign rise = src & ~src_d & rise_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d <= src;   // a level already high at reset release is not an edge
      lat   <= '0;
    end else begin
      src_d <= src;
      lat   <= (rd_clr ? '0 : lat) | rise;
    end
  end
endmodule

// File: rtl/ulpi_vendor_ram.sv
`timescale 1ns/1ps
module ulpi_vendor_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ulpi_reg_array.sv
`timescale 1ns/1ps
module ulpi_reg_array
  import ulpi_reg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [NSRC-1:0] irq_src,
  input  logic [1:0]      line_state,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   func_ctrl,
  output logic [DW-1:0]   otg_ctrl
);
  localparam int VIW = $clog2(VEND_DEPTH);

  logic          wr_en, rd_en;
  logic [NALIAS-1:0] al_hit;
  logic [DW-1:0] al_q [NALIAS];
  logic [NSRC-1:0] lat;
  logic [AW-1:0] vend_off;
  logic          vend_hit;
  logic [DW-1:0] vend_q;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rd_hold;
  logic          vend_sel_q;

  assign wr_en = acc_valid & acc_write;
  assign rd_en = acc_valid & ~acc_write;

  for (genvar i = 0; i < NALIAS; i++) begin : g_alias
    ulpi_alias_reg #(.AW(AW), .DW(DW), .BASE(alias_base(i)), .RST_VAL('0)) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(acc_addr),
      .wdata(acc_wdata), .hit(al_hit[i]), .q(al_q[i])
    );
  end

  ulpi_irq_latch #(.N(NSRC)) u_latch (
    .clk(clk), .rst(rst), .src(irq_src),
    .rise_en(al_q[IX_IEN][NSRC-1:0]),
    .rd_clr(rd_en && (acc_addr == A_LATCH)),
    .lat(lat)
  );

  assign vend_off = acc_addr - A_VEND;
  assign vend_hit = vend_off < AW'(VEND_DEPTH);

  ulpi_vendor_ram #(.DEPTH(VEND_DEPTH), .DW(DW)) u_vend (
    .clk(clk), .we(wr_en & vend_hit), .waddr(vend_off[VIW-1:0]),
    .wdata(acc_wdata), .raddr(vend_off[VIW-1:0]), .rdata(vend_q)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NALIAS; i++) begin
      if (al_hit[i]) rd_mux = al_q[i];
    end
    if (acc_addr == A_STATUS) rd_mux = DW'(irq_src);
    if (acc_addr == A_LATCH)  rd_mux = DW'(lat);
    if (acc_addr == A_DEBUG)  rd_mux = DW'(line_state);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_hold    <= '0;
      vend_sel_q <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      vend_sel_q <= rd_en & vend_hit;
      if (rd_en) rd_hold <= rd_mux;
    end
  end

  assign rd_data   = vend_sel_q ? vend_q : rd_hold;
  assign func_ctrl = al_q[IX_FUNC];
  assign otg_ctrl  = al_q[IX_OTG];
endmodule

// File: rtl/ulpi_reg_array_chk.sv
`timescale 1ns/1ps
module ulpi_reg_array_chk
  import ulpi_reg_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [AW-1:0]   acc_addr,
  input logic [DW-1:0]   acc_wdata,
  input logic [NSRC-1:0] irq_src,
  input logic [1:0]      line_state,
  input logic            rd_valid,
  input logic [DW-1:0]   rd_data,
  input logic [DW-1:0]   func_ctrl,
  input logic [DW-1:0]   otg_ctrl
);
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);  // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> !rd_valid);  // R10
  AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_addr == A_FUNC) |=> func_ctrl == $past(acc_wdata));  // R2
  AST_OTG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_addr == A_OTG) |=> otg_ctrl == $past(acc_wdata));  // R2
  AST_FUNC_SET: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_addr == A_FUNC + AW'(1)) |=>
      func_ctrl == ($past(func_ctrl) | $past(acc_wdata)));  // R3
  AST_FUNC_CLR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_addr == A_FUNC + AW'(2)) |=>
      func_ctrl == ($past(func_ctrl) & ~$past(acc_wdata)));  // R3
  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_addr == A_STATUS) |=>
      rd_data == {{(DW-NSRC){1'b0}}, $past(irq_src)});  // R4
  AST_DEBUG_LIVE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_addr == A_DEBUG) |=>
      rd_data == {{(DW-2){1'b0}}, $past(line_state)});  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ($stable(func_ctrl) && $stable(otg_ctrl)));  // R9
endmodule

bind ulpi_reg_array ulpi_reg_array_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .irq_src(irq_src),
  .line_state(line_state), .rd_valid(rd_valid), .rd_data(rd_data),
  .func_ctrl(func_ctrl), .otg_ctrl(otg_ctrl)
);

// File: tb/ulpi_reg_array_test.sv
`timescale 1ns/1ps
module ulpi_reg_array_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [5:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [4:0] irq_src = '0;
  logic [1:0] line_state = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] func_ctrl;
  logic [7:0] otg_ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ulpi_reg_array uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .irq_src(irq_src),
    .line_state(line_state), .rd_valid(rd_valid), .rd_data(rd_data),
    .func_ctrl(func_ctrl), .otg_ctrl(otg_ctrl)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R10 no valid after write", {7'b0, rd_valid}, 8'h00);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    d = rd_data;
    check("R10 valid after read", {7'b0, rd_valid}, 8'h01);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    check("R1 func_ctrl", func_ctrl, 8'h00);
    check("R1 otg_ctrl", otg_ctrl, 8'h00);
    rd(6'h04, d); check("R1 read 04", d, 8'h00);
    rd(6'h0A, d); check("R1 read 0A", d, 8'h00);
    rd(6'h0D, d); check("R1 read 0D", d, 8'h00);
    rd(6'h16, d); check("R1 read 16", d, 8'h00);
    rd(6'h14, d); check("R1 read 14", d, 8'h00);
  endtask

  task automatic test_alias(input logic [5:0] base, input logic [7:0] seed);
    logic [7:0] d, exp;
    exp = seed;
    wr(base, exp);
    if (base == 6'h04) check("R10 func_ctrl follows", func_ctrl, exp);
    if (base == 6'h0A) check("R10 otg_ctrl follows", otg_ctrl, exp);
    for (int k = 0; k < 3; k++) begin
      rd(base + 6'(k), d); check("R2 alias read", d, exp);
    end
    wr(base + 6'd1, 8'h3C); exp = exp | 8'h3C;
    rd(base + 6'd2, d); check("R3 set alias", d, exp);
    wr(base + 6'd2, 8'h81); exp = exp & ~8'h81;
    rd(base, d); check("R3 clear alias", d, exp);
    wr(base + 6'd2, 8'hFF);
    rd(base + 6'd1, d); check("R3 clear all", d, 8'h00);
  endtask

  task automatic test_status();
    logic [7:0] d;
    logic [4:0] pats [4] = '{5'b10101, 5'b01010, 5'b11111, 5'b00000};
    for (int k = 0; k < 4; k++) begin
      irq_src = pats[k];
      rd(6'h13, d); check("R4 status live", d, {3'b0, pats[k]});
    end
  endtask

  task automatic test_debug();
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      line_state = 2'(k);
      rd(6'h15, d); check("R5 debug line state", d, 8'(k));
    end
  endtask

  task automatic test_latch();
    logic [7:0] d;
    wr(6'h0D, 8'h05);               // enable bits 0 and 2
    rd(6'h14, d);                   // start empty
    @(negedge clk); irq_src = 5'b00011;
    @(negedge clk); @(negedge clk);
    rd(6'h14, d); check("R6 enabled rise only", d, 8'h01);
    rd(6'h14, d); check("R7 cleared by read", d, 8'h00);
    irq_src = 5'b00000;
    @(negedge clk); @(negedge clk);
    rd(6'h14, d); check("R6 fall does not set", d, 8'h00);
    irq_src = 5'b00100;
    @(negedge clk); @(negedge clk);
    wr(6'h14, 8'hFF);
    rd(6'h14, d); check("R9 write to latch ignored", d, 8'h04);
    wr(6'h13, 8'hFF);
    rd(6'h13, d); check("R9 write to status ignored", d, 8'h04);
    line_state = 2'b10;
    wr(6'h15, 8'hFF);
    rd(6'h15, d); check("R9 write to debug ignored", d, 8'h02);
  endtask

  task automatic test_race();
    logic [7:0] d;
    irq_src = 5'b00000;
    @(negedge clk); @(negedge clk);
    rd(6'h14, d); check("R7 race precondition", d, 8'h00);
    @(negedge clk);
    irq_src = 5'b00100;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 6'h14;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R7 read during rise returns old", rd_data, 8'h00);
    rd(6'h14, d); check("R7 rise during read kept", d, 8'h04);
    wr(6'h0F, 8'h01);
    rd(6'h0E, d); check("R3 enable clear alias", d, 8'h04);
  endtask

  task automatic test_vendor();
    logic [7:0] d;
    for (int k = 0; k < 16; k++) wr(6'h30 + 6'(k), 8'(k * 17) ^ 8'h3C);
    for (int k = 0; k < 16; k++) begin
      rd(6'h30 + 6'(k), d); check("R8 vendor byte", d, 8'(k * 17) ^ 8'h3C);
    end
  endtask

  task automatic test_unimpl();
    logic [7:0] d;
    wr(6'h01, 8'hAA);
    wr(6'h20, 8'h55);
    rd(6'h01, d); check("R9 unimplemented 01", d, 8'h00);
    rd(6'h19, d); check("R9 unimplemented 19", d, 8'h00);
    rd(6'h20, d); check("R9 unimplemented 20", d, 8'h00);
    rd(6'h2F, d); check("R9 unimplemented 2F", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_alias(6'h04, 8'hA5);
    test_alias(6'h0A, 8'h5A);
    test_alias(6'h0D, 8'hC3);
    test_alias(6'h16, 8'h96);
    test_status();
    test_debug();
    test_latch();
    test_race();
    test_vendor();
    test_unimpl();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule